// File: doc/BRIEF.md
# Set-Associative Cache with Not-Last-Used Replacement

This block is the lookup and replacement engine of a read/write cache with several ways. A request carries a word address: its low `log2(SETS)` bits pick a set, and the remaining upper bits form the tag. Each way is a direct-mapped bank of its own. All banks are read at the same index, and their stored tags are compared with the request tag in parallel. A match is reported in the same cycle, and on a read the matching way's word is returned in that cycle.

On a read miss the block picks a way to refill. The lowest-numbered invalid way is taken if one exists. Otherwise the block takes the lowest-numbered way that is not the one last used in that set. It then reads the missing word from a memory with a fixed latency and installs it.

Writes go through to memory. A write that hits also updates the cached word. A write that misses goes only to memory and allocates nothing. While a refill is in progress, the block is not ready and ignores any request.

Top module: `nwc_top`

## Requirements
- R1: After reset every line is invalid, `ready` is 1, and `rsp_valid`, `mem_rd` and `mem_we` are 0 while no request is presented. The first read of any address after reset misses.
- R2: A read that hits sets `lookup_hit` and `rsp_valid` in the cycle the request is accepted, with `rsp_data` equal to the cached word. It causes no memory read, and `ready` stays 1 in the next cycle.
- R3: A read miss holds `mem_rd` at 1 with `mem_addr` equal to the miss address for exactly `MEM_LAT` cycles, beginning in the cycle after acceptance. `ready` is 0 during those cycles. `rsp_valid` is 1 only in the last of them, where `rsp_data` equals `mem_rdata`. The word is then installed.
- R4: Up to `WAYS` different tags that share one index can be held at the same time, and all of them hit. At most one way matches at a time.
- R5: On a read miss where some way of the set is invalid, the refill goes to the lowest-numbered invalid way, and no valid line is evicted.
- R6: On a read miss where all ways of the set are valid, the refill goes to the lowest-numbered way other than the set's last-used way. The last-used way is updated on every hit, whether read or write, and on every refill.
- R7: A write that hits updates the cached word and, in the same cycle, drives `mem_we` = 1 with `mem_addr` and `mem_wdata` equal to the request.
- R8: A write that misses drives `mem_we` = 1 with the request address and data, allocates no line (a later read of that address misses), and does not stall: `ready` stays 1 and `mem_rd` stays 0.
- R9: A request presented while `ready` is 0 is ignored: it causes no memory write and no lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address: low log2(SETS) bits select the set, upper bits are the tag |
| req_wdata | input | DW | Write data |
| ready | output | 1 | Block accepts a request this cycle |
| lookup_hit | output | 1 | An accepted request matched a valid way |
| rsp_valid | output | 1 | Read data valid (read hit, or the last cycle of a refill) |
| rsp_data | output | DW | Read data |
| mem_rd | output | 1 | Memory read in progress |
| mem_we | output | 1 | Single-cycle memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, sampled in the last refill cycle |

## Verification
A write hit does two things in one cycle: it updates the cached word and it drives the memory write strobe. The bench presents a write to an address that is already resident. In that cycle it checks both the hit flag and the memory write port, including address and data. It then reads the address back and expects a same-cycle hit that returns the new word. Write misses are judged the opposite way: the memory write must appear, and no refill may start.

// File: rtl/nwc_pkg.sv
package nwc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } nwc_state_t;
endpackage

// File: rtl/nwc_bank.sv
module nwc_bank #(
  parameter int SETS = 16,
  parameter int IW   = 4,
  parameter int TW   = 28,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] look_idx,
  input  logic [TW-1:0] look_tag,
  output logic          match_o,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [TW-1:0] wr_tag,
  input  logic [DW-1:0] wr_data
);
  logic [SETS-1:0] line_ok;
  logic [TW-1:0]   tag_arr  [SETS];
  logic [DW-1:0]   word_arr [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_ok <= '0;
    else if (wr_en) line_ok[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_arr[wr_idx]  <= wr_tag;
      word_arr[wr_idx] <= wr_data;
    end
  end

  assign valid_o = line_ok[look_idx];
  assign match_o = valid_o && (tag_arr[look_idx] == look_tag);
  assign data_o  = word_arr[look_idx];
endmodule

// File: rtl/nwc_lru.sv
module nwc_lru #(
  parameter int SETS = 16,
  parameter int IW   = 4,
  parameter int WB   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic [WB-1:0] last_o,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic [WB-1:0] upd_way
);
  logic [WB-1:0] last_arr [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) last_arr[s] <= '0;
    end else if (upd_en) begin
      last_arr[upd_idx] <= upd_way;
    end
  end

  assign last_o = last_arr[rd_idx];
endmodule

// File: rtl/nwc_top.sv
module nwc_top #(
  parameter int WAYS    = 4,
  parameter int SETS    = 16,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int MEM_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic          lookup_hit,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  import nwc_pkg::*;

  localparam int IW = $clog2(SETS);
  localparam int TW = AW - IW;
  localparam int WB = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int CW = $clog2(MEM_LAT + 1);

  // lowest set bit of a way vector
  function automatic logic [WB-1:0] first_set(input logic [WAYS-1:0] v);
    logic [WB-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) if (v[i]) r = WB'(i);
    return r;
  endfunction

  // invalid way first, else lowest way that is not the last used
  function automatic logic [WB-1:0] victim_of(input logic [WAYS-1:0] vld,
                                              input logic [WB-1:0]   last);
    logic [WAYS-1:0] cand;
    if (!(&vld)) cand = ~vld;
    else begin
      cand = '1;
      cand[last] = 1'b0;
    end
    return first_set(cand);
  endfunction

  nwc_state_t    state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] f_addr;
  logic [WB-1:0] f_way;

  logic [IW-1:0] idx;
  logic [TW-1:0] tag;
  assign idx = req_addr[IW-1:0];
  assign tag = req_addr[AW-1:IW];

  logic [WAYS-1:0] match_vec;
  logic [WAYS-1:0] valid_vec;
  logic [DW-1:0]   bank_data [WAYS];
  logic [WAYS-1:0] bank_we;
  logic [IW-1:0]   w_idx;
  logic [TW-1:0]   w_tag;
  logic [DW-1:0]   w_data;
  logic [WB-1:0]   last_ptr;
  logic [WB-1:0]   hit_way;
  logic [WB-1:0]   victim;

  // named events
  logic accept, any_hit, rd_hit, wr_hit, rd_miss, wr_miss, fill_done;
  assign accept    = req_valid && (state == ST_IDLE);
  assign any_hit   = |match_vec;
  assign rd_hit    = accept && any_hit && !req_write;
  assign wr_hit    = accept && any_hit && req_write;
  assign rd_miss   = accept && !any_hit && !req_write;
  assign wr_miss   = accept && !any_hit && req_write;
  assign fill_done = (state == ST_FILL) && (cnt == CW'(MEM_LAT - 1));

  assign hit_way = first_set(match_vec);
  assign victim  = victim_of(valid_vec, last_ptr);

  assign w_idx  = fill_done ? f_addr[IW-1:0]  : idx;
  assign w_tag  = fill_done ? f_addr[AW-1:IW] : tag;
  assign w_data = fill_done ? mem_rdata       : req_wdata;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign bank_we[w] = (wr_hit && match_vec[w]) ||
                        (fill_done && (f_way == WB'(w)));
    nwc_bank #(.SETS(SETS), .IW(IW), .TW(TW), .DW(DW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .look_idx(idx), .look_tag(tag),
      .match_o(match_vec[w]), .valid_o(valid_vec[w]), .data_o(bank_data[w]),
      .wr_en(bank_we[w]), .wr_idx(w_idx), .wr_tag(w_tag), .wr_data(w_data)
    );
  end

  nwc_lru #(.SETS(SETS), .IW(IW), .WB(WB)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(idx), .last_o(last_ptr),
    .upd_en(rd_hit || wr_hit || fill_done),
    .upd_idx(w_idx),
    .upd_way(fill_done ? f_way : hit_way)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      f_addr <= '0;
      f_way  <= '0;
    end else if (state == ST_IDLE) begin
      if (rd_miss) begin
        state  <= ST_FILL;
        cnt    <= '0;
        f_addr <= req_addr;
        f_way  <= victim;
      end
    end else if (fill_done) begin
      state <= ST_IDLE;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  logic [DW-1:0] hit_data;
  always_comb begin
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) if (match_vec[w]) hit_data = hit_data | bank_data[w];
  end

  assign ready      = (state == ST_IDLE);
  assign lookup_hit = accept && any_hit;
  assign rsp_valid  = rd_hit || fill_done;
  assign rsp_data   = fill_done ? mem_rdata : hit_data;
  assign mem_rd     = (state == ST_FILL);
  assign mem_we     = wr_hit || wr_miss;
  assign mem_addr   = (state == ST_FILL) ? f_addr : req_addr;
  assign mem_wdata  = req_wdata;
endmodule

// File: rtl/nwc_checker.sv
module nwc_checker #(
  parameter int WAYS = 4,
  parameter int WB   = 2,
  parameter int AW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ready,
  input logic            mem_rd,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic [WAYS-1:0] match_vec,
  input logic [WAYS-1:0] valid_vec,
  input logic [WB-1:0]   last_ptr,
  input logic [WB-1:0]   victim,
  input logic            rd_miss,
  input logic            wr_hit,
  input logic            wr_miss,
  input logic            fill_done
);
  p_fill_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_miss |=> (mem_rd && !ready));
  p_fill_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (!mem_rd && ready));
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> $stable(mem_addr));
  p_one_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
  p_invalid_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_miss && !(&valid_vec)) |-> !valid_vec[victim]);
  p_not_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_miss && (&valid_vec) && (WAYS > 1)) |-> (victim != last_ptr));
  p_write_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |-> mem_we);
  p_write_around_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_miss |=> (ready && !mem_rd));
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !mem_we);
endmodule

bind nwc_top nwc_checker #(.WAYS(WAYS), .WB(WB), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .mem_rd(mem_rd), .mem_we(mem_we),
  .mem_addr(mem_addr), .match_vec(match_vec), .valid_vec(valid_vec),
  .last_ptr(last_ptr), .victim(victim), .rd_miss(rd_miss), .wr_hit(wr_hit),
  .wr_miss(wr_miss), .fill_done(fill_done)
);

// File: tb/tb_nwc_top.sv
`timescale 1ns/1ps
module tb_nwc_top;
  localparam int WAYS = 4, SETS = 16, AW = 32, DW = 32, LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ready, lookup_hit, rsp_valid, mem_rd, mem_we;
  logic [DW-1:0] rsp_data, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nwc_top #(.WAYS(WAYS), .SETS(SETS), .AW(AW), .DW(DW), .MEM_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
    .lookup_hit(lookup_hit), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: written words override a hashed background
  logic [DW-1:0] wmem [logic [AW-1:0]];
  function automatic logic [DW-1:0] fetch(input logic [AW-1:0] a);
    if (wmem.exists(a)) return wmem[a];
    return (a * 32'h9E37_79B9) ^ 32'h5A5A_0000;
  endfunction
  always @(negedge clk) begin
    if (mem_we) wmem[mem_addr] = mem_wdata;
    mem_rdata <= fetch(mem_addr);
  end

  // word address: set in low 4 bits, tag above
  function automatic logic [AW-1:0] A(input int t, input int s);
    return AW'(t * SETS + s);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit exp_hit, input string rq);
    logic [DW-1:0] e;
    int n;
    e = fetch(a);
    @(posedge clk); #1;
    req_valid = 1; req_write = 0; req_addr = a;
    #0.5;
    chk(lookup_hit === exp_hit, rq, lookup_hit, exp_hit);
    if (exp_hit) chk(rsp_valid && rsp_data == e, rq, rsp_data, e);
    @(posedge clk); #1;
    req_valid = 0;
    if (exp_hit) begin
      #0.5;
      chk(ready && !mem_rd, {rq, " no refill after hit (R2)"}, mem_rd, 0);
    end else begin
      #0.5;
      chk(mem_rd && mem_addr == a && !ready, {rq, " refill start (R3)"}, mem_addr, a);
      n = 1;
      while (!rsp_valid && n < 50) begin
        @(posedge clk); #1.5;
        n++;
      end
      chk(n == LAT, {rq, " refill latency (R3)"}, n, LAT);
      chk(rsp_data == e, {rq, " refill data (R3)"}, rsp_data, e);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit exp_hit, input string rq);
    @(posedge clk); #1;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    #0.5;
    chk(lookup_hit === exp_hit, {rq, " hit flag"}, lookup_hit, exp_hit);
    chk(mem_we && mem_addr == a && mem_wdata == d, {rq, " memory write"},
        {mem_we, mem_addr}, {1'b1, a});
    @(posedge clk); #1;
    req_valid = 0;
    #0.5;
    chk(ready && !mem_rd, {rq, " no stall"}, {ready, mem_rd}, 2'b10);
  endtask

  task automatic t_reset;
    chk(ready && !rsp_valid && !mem_rd && !mem_we, "R1 reset outputs",
        {ready, rsp_valid, mem_rd, mem_we}, 4'b1000);
    do_read(A(1, 0), 0, "R1 first read misses");
  endtask

  task automatic t_hit;
    do_read(A(1, 0), 1, "R2 read hit");
    do_read(A(7, 9), 0, "R3 read miss");
    do_read(A(7, 9), 1, "R2 hit after fill");
  endtask

  task automatic t_full_set;
    for (int t = 1; t <= WAYS; t++) do_read(A(t, 1), 0, "R4 fill set");
    for (int t = 1; t <= WAYS; t++) do_read(A(t, 1), 1, "R4 all ways held");
    // last used = way3 (tag4); victim lowest other = way0 (tag1)
    do_read(A(5, 1), 0, "R6 miss full set");
    do_read(A(2, 1), 1, "R6 tag2 kept");
    do_read(A(3, 1), 1, "R6 tag3 kept");
    do_read(A(4, 1), 1, "R6 tag4 kept");
    do_read(A(5, 1), 1, "R6 tag5 resident");
    // last used = way0 (tag5); tag1 refills way1 evicting tag2
    do_read(A(1, 1), 0, "R6 tag1 was evicted");
    do_read(A(2, 1), 0, "R6 tag2 evicted, not last used way0");
  endtask

  task automatic t_not_last;
    for (int t = 1; t <= WAYS; t++) do_read(A(t, 2), 0, "R6 fill set2");
    do_read(A(1, 2), 1, "R6 touch way0");
    // way0 last used: victim way1 (tag2), tag1 survives
    do_read(A(5, 2), 0, "R6 miss set2");
    do_read(A(1, 2), 1, "R6 last-used way kept");
    do_read(A(2, 2), 0, "R6 lowest other way evicted");
  endtask

  task automatic t_invalid_first;
    do_read(A(1, 3), 0, "R5 fill way0");
    do_read(A(2, 3), 0, "R5 fill way1");
    do_read(A(3, 3), 0, "R5 miss with invalid ways");
    do_read(A(1, 3), 1, "R5 valid way0 kept");
    do_read(A(2, 3), 1, "R5 valid way1 kept");
  endtask

  task automatic t_write_hit;
    do_write(A(1, 0), 32'hCAFE_0001, 1, "R7 write hit");
    do_read(A(1, 0), 1, "R7 updated word read back");
  endtask

  task automatic t_write_miss;
    do_write(A(9, 5), 32'hBEEF_0005, 0, "R8 write miss");
    do_read(A(9, 5), 0, "R8 no allocation, memory holds data");
  endtask

  task automatic t_busy_ignore;
    @(posedge clk); #1;
    req_valid = 1; req_write = 0; req_addr = A(3, 7);
    @(posedge clk); #1;
    req_write = 1; req_addr = A(6, 7); req_wdata = 32'h1234_5678;
    #0.5;
    chk(!mem_we && !lookup_hit && !ready, "R9 request ignored while busy",
        {mem_we, lookup_hit, ready}, 3'b000);
    for (int k = 1; k < LAT; k++) begin
      @(posedge clk); #1.5;
    end
    chk(rsp_valid && rsp_data == fetch(A(3, 7)), "R9 refill unaffected", rsp_data, fetch(A(3, 7)));
    req_valid = 0;
    chk(!wmem.exists(A(6, 7)), "R9 no memory write recorded", 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1.5;
    t_reset();
    t_hit();
    t_full_set();
    t_not_last();
    t_invalid_first();
    t_write_hit();
    t_write_miss();
    t_busy_ignore();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule